// File: doc/BRIEF.md
# One-Wire ROM Command Responder

This block is the addressing layer of a one-wire slave. It sits between a bit-slot transceiver and the memory command layer. After every bus reset/presence sequence it collects an 8-bit command from the host and runs one of five identifier commands: read the identifier, match it, skip it, search for it by arbitration, or search for it only while an alarm interrupt is pending. When the exchange completes with this device still taking part, it raises `selected`, which hands the bus to the memory command layer until the next bus reset.

The transceiver reports each completed write slot as a one-cycle `rx_valid` with the sampled `rx_bit`, and each completed read slot as a one-cycle `rd_slot`. During a read slot it drives the line with `tx_bit`, where 1 means release and 0 means pull low. The 64-bit identifier is fixed by parameters for the family code and serial number. Its CRC byte is computed at elaboration. A serial CRC-8 checker follows the bits sent by the read command.

States: WAIT (idle after power-up or a dropped exchange; only a bus reset leaves it), CMD (collecting command bits), READ (sending identifier bits), MATCH (comparing received bits), S_BIT / S_CMP / S_DIR (the three search steps), SEL (selected). Transitions: any state to CMD on bus reset. CMD to READ, MATCH, S_BIT or SEL on a recognised byte, and CMD to WAIT otherwise. READ to SEL after bit 63. MATCH to WAIT on a mismatch, and MATCH to SEL after bit 63. S_BIT to S_CMP and S_CMP to S_DIR on a read slot. S_DIR to WAIT on a mismatch, S_DIR to S_BIT on a match, and S_DIR to SEL after bit 63.

Top module: `onewire_rom_responder`

## Requirements
- R1: After `rst_n` the block is in WAIT with `selected`=0 and `tx_bit`=1. Bit events are ignored until the first `bus_reset`.
- R2: Identifier bit i is sent as bit i. Bits 7:0 are the family code, bits 55:8 the serial number and bits 63:56 the CRC of bits 55:0. The CRC uses polynomial x^8+x^5+x^4+1, starts at zero and takes bits in index order. Passing all 64 bits through it gives zero.
- R3: After `bus_reset` the next 8 `rx_valid` bits form the command, first bit as bit 0. Read slots during this phase leave `tx_bit`=1.
- R4: Command 33h presents identifier bit i on `tx_bit` for the (i+1)-th read slot. After the 64th slot, `selected`=1.
- R5: Command 55h compares 64 received bits with the identifier. A full match gives `selected`=1. Any mismatch sends the block to WAIT (`selected`=0, `tx_bit`=1), and it ignores further bits.
- R6: Command F0h runs three steps for each bit i: a read slot carrying bit i, a read slot carrying its complement, then a write of the host's choice. A choice unequal to bit i sends the block to WAIT. A matching choice at bit 63 gives `selected`=1.
- R7: Command ECh behaves as F0h when `alarm_pending`=1 at the eighth command bit. Otherwise it sends the block to WAIT.
- R8: Command CCh gives `selected`=1 in the cycle after the eighth command bit.
- R9: Any other command byte sends the block to WAIT with `selected`=0 and `tx_bit`=1.
- R10: `bus_reset` returns the block to CMD with `selected`=0 from any state. It wins over a bit event in the same cycle.
- R11: Once selected, the block stays selected with `tx_bit`=1 until `bus_reset`, whatever bit events arrive.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_reset | input | 1 | One-cycle pulse: bus reset/presence sequence finished |
| rx_valid | input | 1 | One-cycle pulse: write slot received |
| rx_bit | input | 1 | Bit value of the received write slot |
| rd_slot | input | 1 | One-cycle pulse: read slot completed using `tx_bit` |
| alarm_pending | input | 1 | An unacknowledged alarm interrupt is pending |
| tx_bit | output | 1 | Bit for the current read slot (1 = release) |
| selected | output | 1 | Device is addressed; memory command layer may run |

## Verification
Two events can land in one cycle: a bus reset and a bit event (a write slot or a read slot). The bench drives `bus_reset` together with `rx_valid` in the same cycle, both while the block is selected and partway through a command byte. It then checks that `selected` is low one cycle later and that a fresh command byte decodes from its first bit. A leftover bit from the coinciding event would shift the command and break that decode.

// File: rtl/owr_pkg.sv
package owr_pkg;

    typedef enum logic [3:0] {
        ST_WAIT, ST_CMD, ST_READ, ST_MATCH, ST_S_BIT, ST_S_CMP, ST_S_DIR, ST_SEL
    } owr_state_e;

    typedef enum logic [2:0] {
        K_READ, K_MATCH, K_SEARCH, K_SKIP, K_BAD
    } owr_kind_e;

    localparam logic [7:0] OP_READ   = 8'h33;
    localparam logic [7:0] OP_MATCH  = 8'h55;
    localparam logic [7:0] OP_SEARCH = 8'hF0;
    localparam logic [7:0] OP_ASRCH  = 8'hEC;
    localparam logic [7:0] OP_SKIP   = 8'hCC;

    localparam logic [7:0] CRC_POLY_REFL = 8'h8C;

    function automatic logic [7:0] crc8_step(input logic [7:0] c, input logic b);
        logic fb;
        fb = c[0] ^ b;
        crc8_step = (c >> 1) ^ (fb ? CRC_POLY_REFL : 8'h00);
    endfunction

    function automatic logic [7:0] crc8_of56(input logic [55:0] d);
        logic [7:0] c;
        c = 8'h00;
        for (int i = 0; i < 56; i++) c = crc8_step(c, d[i]);
        crc8_of56 = c;
    endfunction

endpackage

// File: rtl/owr_crc8.sv
module owr_crc8
    import owr_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       clr,
    input  logic       en,
    input  logic       din,
    output logic [7:0] crc
);
    always_ff @(posedge clk) begin
        if (!rst_n || clr) crc <= 8'h00;
        else if (en)       crc <= crc8_step(crc, din);
    end
endmodule

// File: rtl/owr_id_rom.sv
module owr_id_rom
    import owr_pkg::*;
#(
    parameter logic [7:0]  FAMILY = 8'h2C,
    parameter logic [47:0] SERIAL = 48'h5A17C3E90B64
) (
    output logic [63:0] id
);
    localparam logic [55:0] BODY = {SERIAL, FAMILY};
    localparam logic [7:0]  TAG  = crc8_of56(BODY);
    assign id = {TAG, BODY};
endmodule

// File: rtl/owr_cmd_decode.sv
module owr_cmd_decode
    import owr_pkg::*;
(
    input  logic [7:0] op,
    input  logic       alarm,
    output owr_kind_e  kind
);
    always_comb begin
        unique case (op)
            OP_READ:   kind = K_READ;
            OP_MATCH:  kind = K_MATCH;
            OP_SEARCH: kind = K_SEARCH;
            OP_ASRCH:  kind = alarm ? K_SEARCH : K_BAD;
            OP_SKIP:   kind = K_SKIP;
            default:   kind = K_BAD;
        endcase
    end
endmodule

// File: rtl/onewire_rom_responder.sv
module onewire_rom_responder
    import owr_pkg::*;
#(
    parameter logic [7:0]  FAMILY = 8'h2C,
    parameter logic [47:0] SERIAL = 48'h5A17C3E90B64,
    parameter int          ID_W   = 64,
    parameter int          CMD_W  = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic bus_reset,
    input  logic rx_valid,
    input  logic rx_bit,
    input  logic rd_slot,
    input  logic alarm_pending,
    output logic tx_bit,
    output logic selected
);
    localparam int IDX_W = $clog2(ID_W);
    localparam int CNT_W = $clog2(CMD_W);
    localparam logic [IDX_W-1:0] IDX_LAST = IDX_W'(ID_W - 1);
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(CMD_W - 1);

    owr_state_e       state_q, state_d;
    logic [IDX_W-1:0] idx_q, idx_d;
    logic [CNT_W-1:0] cnt_q, cnt_d;
    logic [CMD_W-1:0] sr_q, sr_d;
    logic [63:0]      id;
    logic             id_bit;
    logic [CMD_W-1:0] op_full;
    owr_kind_e        kind;

    owr_id_rom #(.FAMILY(FAMILY), .SERIAL(SERIAL)) u_id (.id(id));

    assign id_bit  = id[idx_q];
    assign op_full = {rx_bit, sr_q[CMD_W-1:1]};

    owr_cmd_decode u_dec (.op(op_full[7:0]), .alarm(alarm_pending), .kind(kind));

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_WAIT;
            idx_q   <= '0;
            cnt_q   <= '0;
            sr_q    <= '0;
        end else begin
            state_q <= state_d;
            idx_q   <= idx_d;
            cnt_q   <= cnt_d;
            sr_q    <= sr_d;
        end
    end

    // next state
    always_comb begin
        state_d = state_q;
        idx_d   = idx_q;
        cnt_d   = cnt_q;
        sr_d    = sr_q;
        if (bus_reset) begin
            state_d = ST_CMD;
            idx_d   = '0;
            cnt_d   = '0;
        end else begin
            unique case (state_q)
                ST_WAIT, ST_SEL: ;
                ST_CMD: if (rx_valid) begin
                    sr_d  = op_full;
                    cnt_d = cnt_q + 1'b1;
                    if (cnt_q == CNT_LAST) begin
                        idx_d = '0;
                        unique case (kind)
                            K_READ:   state_d = ST_READ;
                            K_MATCH:  state_d = ST_MATCH;
                            K_SEARCH: state_d = ST_S_BIT;
                            K_SKIP:   state_d = ST_SEL;
                            default:  state_d = ST_WAIT;
                        endcase
                    end
                end
                ST_READ: if (rd_slot) begin
                    idx_d = idx_q + 1'b1;
                    if (idx_q == IDX_LAST) state_d = ST_SEL;
                end
                ST_MATCH, ST_S_DIR: if (rx_valid) begin
                    idx_d = idx_q + 1'b1;
                    if (rx_bit != id_bit)       state_d = ST_WAIT;
                    else if (idx_q == IDX_LAST) state_d = ST_SEL;
                    else if (state_q == ST_S_DIR) state_d = ST_S_BIT;
                end
                ST_S_BIT: if (rd_slot) state_d = ST_S_CMP;
                ST_S_CMP: if (rd_slot) state_d = ST_S_DIR;
                default:  state_d = ST_WAIT;
            endcase
        end
    end

    // outputs
    always_comb begin
        selected = (state_q == ST_SEL);
        unique case (state_q)
            ST_READ, ST_S_BIT: tx_bit = id_bit;
            ST_S_CMP:          tx_bit = ~id_bit;
            default:           tx_bit = 1'b1;
        endcase
    end

    // serial CRC over the bits sent by the read command
    logic [7:0] crc_run;
    logic       read_done_q;
    owr_crc8 u_crc (
        .clk(clk), .rst_n(rst_n), .clr(bus_reset),
        .en(rd_slot && state_q == ST_READ), .din(tx_bit), .crc(crc_run)
    );
    always_ff @(posedge clk) begin
        if (!rst_n) read_done_q <= 1'b0;
        else        read_done_q <= !bus_reset && rd_slot && state_q == ST_READ && idx_q == IDX_LAST;
    end

    // R2: the whole identifier leaves a zero residue
    a_r2_crc_residue: assert property (@(posedge clk) disable iff (!rst_n)
        read_done_q |-> crc_run == 8'h00);
    // R10: a bus reset always deselects
    a_r10_reset_deselects: assert property (@(posedge clk) disable iff (!rst_n)
        bus_reset |=> !selected);
    // R11: selection holds until a bus reset
    a_r11_sel_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (selected && !bus_reset) |=> selected);
    // R11: a selected device never pulls the line
    a_r11_sel_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        selected |-> tx_bit);
    // R4: selection only follows a bit event
    a_r4_sel_cause: assert property (@(posedge clk) disable iff (!rst_n)
        (!selected && !bus_reset) |=> (!selected || $past(rx_valid || rd_slot)));
endmodule

// File: tb/onewire_rom_responder_test.sv
`timescale 1ns/1ps
module onewire_rom_responder_test;
    localparam logic [7:0]  FAM = 8'h2C;
    localparam logic [47:0] SER = 48'h5A17C3E90B64;

    logic clk = 0, rst_n = 0, bus_reset = 0, rx_valid = 0, rx_bit = 0;
    logic rd_slot = 0, alarm_pending = 0;
    logic tx_bit, selected;
    int n_cmp = 0, n_bad = 0, cycles = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    onewire_rom_responder #(.FAMILY(FAM), .SERIAL(SER)) uut (
        .clk(clk), .rst_n(rst_n), .bus_reset(bus_reset), .rx_valid(rx_valid),
        .rx_bit(rx_bit), .rd_slot(rd_slot), .alarm_pending(alarm_pending),
        .tx_bit(tx_bit), .selected(selected)
    );

    // bench CRC model: explicit shift register stages
    function automatic logic [7:0] ref_crc(input logic [63:0] d, input int n);
        logic [7:0] s;
        logic fb;
        s = 0;
        for (int i = 0; i < n; i++) begin
            fb = s[0] ^ d[i];
            s = {fb, s[7:1]};
            s[3] = s[3] ^ fb;
            s[2] = s[2] ^ fb;
        end
        return s;
    endfunction

    logic [63:0] exp_id;

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic tick(); @(negedge clk); endtask

    task automatic do_breset(input logic with_bit = 0);
        bus_reset = 1; rx_valid = with_bit; rx_bit = 1;
        tick(); bus_reset = 0; rx_valid = 0;
    endtask

    task automatic wbit(input logic b);
        rx_valid = 1; rx_bit = b; tick(); rx_valid = 0;
    endtask

    task automatic rbit(output logic b);
        b = tx_bit; rd_slot = 1; tick(); rd_slot = 0;
    endtask

    task automatic wbyte(input logic [7:0] v);
        for (int i = 0; i < 8; i++) wbit(v[i]);
    endtask

    // full search exchange; bad_at < 0 means host follows the identifier
    task automatic search(input string req, input int bad_at);
        logic b, c;
        for (int i = 0; i < 64; i++) begin
            rbit(b); rbit(c);
            check(req, {62'd0, b, c}, {62'd0, exp_id[i], ~exp_id[i]});
            wbit(i == bad_at ? ~exp_id[i] : exp_id[i]);
            if (i == bad_at) begin
                check(req, {63'd0, selected}, 64'd0);
                rbit(b); check(req, {63'd0, b}, 64'd1);
                break;
            end
        end
        if (bad_at < 0) check(req, {63'd0, selected}, 64'd1);
    endtask

    initial begin
        logic b;
        logic [63:0] got;
        logic [7:0] op;
        int k;
        void'($urandom(32'd4711));
        exp_id = {ref_crc({8'd0, SER, FAM}, 56), SER, FAM};
        tick(); tick(); rst_n = 1; tick();

        // R1 reset state, bits ignored before first bus reset
        check("R1 sel", {63'd0, selected}, 64'd0);
        check("R1 tx", {63'd0, tx_bit}, 64'd1);
        wbyte(8'hCC);
        check("R1 ignored", {63'd0, selected}, 64'd0);

        // R2 identifier residue
        check("R2 residue", {56'd0, ref_crc(exp_id, 64)}, 64'd0);

        // R4 read identifier
        do_breset(); wbyte(8'h33);
        for (int i = 0; i < 64; i++) begin rbit(b); got[i] = b; end
        check("R4 id", got, exp_id);
        check("R2 read crc", {56'd0, ref_crc(got, 64)}, 64'd0);
        check("R4 sel", {63'd0, selected}, 64'd1);

        // R11 stays selected
        wbyte(8'h00); rbit(b);
        check("R11 hold", {62'd0, selected, b}, 64'd3);

        // R3 read slots during command; R8 skip
        do_breset(); rbit(b);
        check("R3 tx", {63'd0, b}, 64'd1);
        wbyte(8'hCC);
        check("R8 skip", {63'd0, selected}, 64'd1);

        // R5 full match
        do_breset(); wbyte(8'h55);
        for (int i = 0; i < 64; i++) wbit(exp_id[i]);
        check("R5 match", {63'd0, selected}, 64'd1);

        // R6 full search, R7 alarm search
        do_breset(); wbyte(8'hF0); search("R6 search", -1);
        alarm_pending = 1;
        do_breset(); wbyte(8'hEC); search("R7 alarm search", -1);
        alarm_pending = 0;
        do_breset(); wbyte(8'hEC); rbit(b);
        check("R7 no alarm", {62'd0, selected, b}, 64'd1);
        wbyte(8'hCC);
        check("R7 stays idle", {63'd0, selected}, 64'd0);

        // R10 reset coinciding with a bit event
        do_breset(); wbyte(8'hCC);
        do_breset(1);
        check("R10 desel", {63'd0, selected}, 64'd0);
        wbyte(8'h33); rbit(b);
        check("R10 fresh cmd", {63'd0, b}, {63'd0, exp_id[0]});
        do_breset(); wbit(0); wbit(0); wbit(1);
        do_breset(1); wbyte(8'hCC);
        check("R10 mid cmd", {63'd0, selected}, 64'd1);

        // randomized mix
        for (int it = 0; it < 40; it++) begin
            k = $urandom_range(63);
            do_breset();
            case ($urandom_range(4))
                0: begin
                    wbyte(8'h55);
                    for (int i = 0; i < 64; i++) wbit(i == k ? ~exp_id[i] : exp_id[i]);
                    rbit(b);
                    check("R5 mismatch", {62'd0, selected, b}, 64'd1);
                end
                1: begin wbyte(8'hF0); search("R6 dropout", k); end
                2: begin
                    alarm_pending = 1; wbyte(8'hEC); alarm_pending = 0;
                    search("R7 dropout", k);
                end
                3: begin
                    do op = 8'($urandom());
                    while (op == 8'h33 || op == 8'h55 || op == 8'hF0 || op == 8'hEC || op == 8'hCC);
                    wbyte(op); rbit(b);
                    check("R9 unknown", {62'd0, selected, b}, 64'd1);
                end
                default: begin
                    wbyte(8'h33);
                    for (int i = 0; i < 64; i++) begin rbit(b); got[i] = b; end
                    check("R4 id rnd", got, exp_id);
                end
            endcase
        end

        if (!done) begin
            done = 1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000 && !done) begin
            done = 1;
            n_cmp++; n_bad++;
            $display("FAIL watchdog actual=%0d expected<150000", cycles);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end
endmodule